// File: doc/BRIEF.md
# PCS Fault and Status Register Block

This block holds two read-only status registers of a 10 Gb/s four-lane PCS. Software reaches them through a simple parallel read port: an address, a one-cycle read strobe and a 16-bit read data word. The serial management framing is handled elsewhere. The sync and alignment state machines are also outside this block.

The fault summary register sits at address 8. It always reports that a device is present. It also reports three fixed speed abilities and two sticky local-fault flags, one for transmit and one for receive. A transmit fault is recorded when the PLL is out of lock. A receive fault is recorded when the lanes are not aligned, when any lane has lost byte sync, or when loss of signal is seen. Both flags stay set until software reads the fault summary register or pulses either of two alarm-clear strobes. Those strobes come from reads of an external alarm-status register.

The lane status register sits at address 24. It shows the live lane-sync flags, the all-lanes-aligned flag, a fixed test-pattern ability bit and a loopback ability bit that follows a configuration input. Every other address reads as zero.

Top module: `pcs_fault_status`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 16'h0000 and both fault flags are clear.
- R2: A read of address 8 returns 2'b10 in bits 15:14 and 3'b010 in bits 2:0 (bit 1 is 10GBASE-X ability, bit 2 is 10GBASE-W and bit 0 is 10GBASE-R). Bits 13:12 and 9:3 read 0.
- R3: Bit 11 of address 8 (TX fault) is set in the cycle after `pll_locked` is low, and it stays set after lock returns until it is cleared.
- R4: Bit 10 of address 8 (RX fault) is set in the cycle after any of these: `lanes_aligned` is low, any bit of `lane_sync` is low, or `sig_lost` is high. It stays set until it is cleared.
- R5: A read of address 8 returns the fault flags as they were before that read, and then clears both flags.
- R6: A one-cycle pulse on `alarm_clr_a` or on `alarm_clr_b` clears both fault flags.
- R7: If a fault condition is present in the same cycle as a clearing read or a clear strobe, the matching flag stays set.
- R8: A read of address 24 returns the following, with all other bits 0:
  - bit 12 = `lanes_aligned`
  - bit 11 = 1
  - bit 10 = `lb_ability_en`
  - bits 3:0 = `lane_sync[3:0]`, sampled live
- R9: A read of any address other than 8 or 24 returns 16'h0000.
- R10: `rd_data` changes only on the clock edge that follows a cycle in which `rd_stb` is high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_locked | input | 1 | Transmit PLL lock indication |
| sig_lost | input | 1 | Receive loss-of-signal indication |
| lane_sync | input | 4 | Per-lane byte sync flags |
| lanes_aligned | input | 1 | All receive lanes aligned |
| lb_ability_en | input | 1 | Loopback ability configuration bit |
| alarm_clr_a | input | 1 | Clear strobe from the first alarm-status read |
| alarm_clr_b | input | 1 | Clear strobe from the second alarm-status read |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register address |
| rd_data | output | 16 | Registered read data |

## Verification
The bench sweeps every combination of PLL lock, loss of signal, alignment, the four lane-sync flags and the loopback bit.
- For each combination it reads the lane status register and then the fault register after the inputs return to healthy. A design whose receive condition missed one source, or whose fault flag were not sticky, would show a zero there.
- A clearing read is tested while the fault is still present. A design that let the clear win would lose an event, and its second read would show zero.
- Each alarm-clear strobe is tested separately.
- Every unmapped address is read. An address decode that is too loose would leak a register image onto those addresses.

// File: rtl/pcs_stat_pkg.sv
// Package: shared register addresses and bit positions for the PCS status
// block. Assumes a 16-bit register word and 5-bit register addresses.
package pcs_stat_pkg;
    localparam int REG_W       = 16;
    localparam int REG_ADDR_W  = 5;
    localparam int FAULT_ADDR  = 8;
    localparam int LSTAT_ADDR  = 24;

    // Fault summary register bit positions
    localparam int FS_PRES_LO  = 14;
    localparam int FS_TX_BIT   = 11;
    localparam int FS_RX_BIT   = 10;
    localparam logic [1:0] FS_PRES_CODE = 2'b10;
    localparam logic [2:0] FS_ABILITY   = 3'b010;

    // Lane status register bit positions
    localparam int LS_ALIGN_BIT = 12;
    localparam int LS_TPAT_BIT  = 11;
    localparam int LS_LB_BIT    = 10;

    typedef struct packed {
        logic tx;
        logic rx;
    } fault_pair_t;
endpackage

// File: rtl/pcs_fault_cond.sv
// Module: derives the raw transmit and receive fault conditions from the
// live line status. Purely combinational; assumes all inputs are already
// synchronous to clk.
module pcs_fault_cond #(
    parameter int NUM_LANES = 4
) (
    input  logic                 pll_locked,
    input  logic                 sig_lost,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic                 lanes_aligned,
    output pcs_stat_pkg::fault_pair_t cond
);
    // Combine the fault sources into one condition per direction
    always_comb begin
        cond.tx = ~pll_locked;
        cond.rx = ~lanes_aligned | ~(&lane_sync) | sig_lost;
    end
endmodule

// File: rtl/pcs_sticky_bit.sv
// Module: one latched-high status flag. It is set by a condition and
// cleared by a clear pulse. A condition that coincides with the clear
// wins, so no event is lost. Assumes a synchronous active-low reset.
module pcs_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic held
);
    // Latch the condition high and drop it only on clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else
            held <= cond | (held & ~clr);
    end

    p_cond_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cond |=> held);
    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cond) |=> !held);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> held);
endmodule

// File: rtl/pcs_stat_readmux.sv
// Module: builds the register images and registers the selected word when
// a read strobe arrives. rd_data holds between reads. Assumes that rd_addr
// is valid whenever rd_stb is high.
module pcs_stat_readmux #(
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = pcs_stat_pkg::REG_ADDR_W,
    parameter int DATA_W    = pcs_stat_pkg::REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  pcs_stat_pkg::fault_pair_t flags,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic                 lanes_aligned,
    input  logic                 lb_ability_en,
    output logic [DATA_W-1:0]    rd_data
);
    import pcs_stat_pkg::*;

    logic [DATA_W-1:0] fault_word;
    logic [DATA_W-1:0] lstat_word;
    logic [DATA_W-1:0] sel_word;

    // Assemble the fault summary image
    always_comb begin
        fault_word = '0;
        fault_word[FS_PRES_LO +: 2] = FS_PRES_CODE;
        fault_word[FS_TX_BIT]       = flags.tx;
        fault_word[FS_RX_BIT]       = flags.rx;
        fault_word[2:0]             = FS_ABILITY;
    end

    // Assemble the lane status image
    always_comb begin
        lstat_word = '0;
        lstat_word[LS_ALIGN_BIT]    = lanes_aligned;
        lstat_word[LS_TPAT_BIT]     = 1'b1;
        lstat_word[LS_LB_BIT]       = lb_ability_en;
        lstat_word[NUM_LANES-1:0]   = lane_sync;
    end

    // Select the addressed image; unmapped addresses read zero
    always_comb begin
        if (rd_addr == ADDR_W'(FAULT_ADDR))
            sel_word = fault_word;
        else if (rd_addr == ADDR_W'(LSTAT_ADDR))
            sel_word = lstat_word;
        else
            sel_word = '0;
    end

    // Capture the selected word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= sel_word;
    end

    p_hold_between_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    p_present_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == ADDR_W'(FAULT_ADDR)) |=> (rd_data[15:14] == 2'b10));
    p_tpat_ability_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == ADDR_W'(LSTAT_ADDR)) |=> rd_data[11]);
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr != ADDR_W'(FAULT_ADDR) && rd_addr != ADDR_W'(LSTAT_ADDR))
        |=> (rd_data == '0));
endmodule

// File: rtl/pcs_fault_status.sv
// Module: top of the PCS fault and status register block. It joins the
// fault condition logic, one sticky flag per direction and the read mux.
// A read of the fault register returns the flags and clears them; either
// alarm-clear strobe also clears them. Assumes single-cycle strobes.
module pcs_fault_status #(
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = pcs_stat_pkg::REG_ADDR_W,
    parameter int DATA_W    = pcs_stat_pkg::REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pll_locked,
    input  logic                 sig_lost,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic                 lanes_aligned,
    input  logic                 lb_ability_en,
    input  logic                 alarm_clr_a,
    input  logic                 alarm_clr_b,
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    import pcs_stat_pkg::*;

    fault_pair_t cond;
    fault_pair_t flags;
    logic        clr_any;

    pcs_fault_cond #(.NUM_LANES(NUM_LANES)) cond_i (
        .pll_locked    (pll_locked),
        .sig_lost      (sig_lost),
        .lane_sync     (lane_sync),
        .lanes_aligned (lanes_aligned),
        .cond          (cond)
    );

    // Any clearing source: own-register read or either alarm read
    always_comb begin
        clr_any = (rd_stb && rd_addr == ADDR_W'(FAULT_ADDR)) | alarm_clr_a | alarm_clr_b;
    end

    pcs_sticky_bit tx_flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond.tx),
        .clr   (clr_any),
        .held  (flags.tx)
    );

    pcs_sticky_bit rx_flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond.rx),
        .clr   (clr_any),
        .held  (flags.rx)
    );

    pcs_stat_readmux #(
        .NUM_LANES (NUM_LANES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) mux_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_stb        (rd_stb),
        .rd_addr       (rd_addr),
        .flags         (flags),
        .lane_sync     (lane_sync),
        .lanes_aligned (lanes_aligned),
        .lb_ability_en (lb_ability_en),
        .rd_data       (rd_data)
    );

    p_alarm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm_clr_a || alarm_clr_b) && pll_locked) |=> !flags.tx);
    p_pll_loss_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> flags.tx);
    p_los_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lost |=> flags.rx);
endmodule

// File: tb/pcs_fault_status_tb_top.sv
module pcs_fault_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_locked = 1'b1;
    logic        sig_lost = 1'b0;
    logic [3:0]  lane_sync = 4'hF;
    logic        lanes_aligned = 1'b1;
    logic        lb_ability_en = 1'b0;
    logic        alarm_clr_a = 1'b0;
    logic        alarm_clr_b = 1'b0;
    logic        rd_stb = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_fault_status dut_i (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .sig_lost(sig_lost),
        .lane_sync(lane_sync), .lanes_aligned(lanes_aligned),
        .lb_ability_en(lb_ability_en), .alarm_clr_a(alarm_clr_a),
        .alarm_clr_b(alarm_clr_b), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read: strobe for one edge, sample at the following negedge
    task automatic do_read(input logic [4:0] a, output logic [15:0] d);
        rd_addr = a;
        rd_stb  = 1'b1;
        @(negedge clk);
        rd_stb  = 1'b0;
        d = rd_data;
    endtask

    task automatic healthy();
        pll_locked = 1'b1; sig_lost = 1'b0; lane_sync = 4'hF; lanes_aligned = 1'b1;
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R2: flags clear after reset, fixed fields
        do_read(5'd8, d);
        check("R1 R2 fault reg after reset", d, 16'h8002);

        // Sweep all input combinations (R3, R4, R8)
        for (int i = 0; i < 256; i++) begin
            logic pl, los, al, lb, rxc;
            logic [3:0] sy;
            pl = i[0]; los = i[1]; al = i[2]; sy = i[6:3]; lb = i[7];
            pll_locked = pl; sig_lost = los; lanes_aligned = al;
            lane_sync = sy; lb_ability_en = lb;
            do_read(5'd24, d);
            exp = {3'b000, al, 1'b1, lb, 6'b0, sy};
            check("R8 lane status", d, exp);
            healthy();
            do_read(5'd8, d);
            rxc = !al || (sy != 4'hF) || los;
            exp = {2'b10, 2'b00, !pl, rxc, 7'b0, 3'b010};
            check("R2 R3 R4 sticky fault", d, exp);
            do_read(5'd8, d);
            check("R5 cleared by read", d, 16'h8002);
        end

        // R7: clearing read while condition still present keeps flag
        pll_locked = 1'b0; sig_lost = 1'b1;
        @(negedge clk);
        do_read(5'd8, d);
        check("R7 first read", d, 16'h8C02);
        do_read(5'd8, d);
        check("R7 flag kept during read", d, 16'h8C02);
        healthy();
        do_read(5'd8, d);
        check("R5 returns pre-clear value", d, 16'h8C02);
        do_read(5'd8, d);
        check("R5 cleared", d, 16'h8002);

        // R6: each alarm strobe clears both flags
        for (int s = 0; s < 2; s++) begin
            pll_locked = 1'b0; lanes_aligned = 1'b0;
            @(negedge clk);
            healthy();
            @(negedge clk);
            if (s == 0) alarm_clr_a = 1'b1; else alarm_clr_b = 1'b1;
            @(negedge clk);
            alarm_clr_a = 1'b0; alarm_clr_b = 1'b0;
            do_read(5'd8, d);
            check(s == 0 ? "R6 clear strobe a" : "R6 clear strobe b", d, 16'h8002);
        end

        // R7: strobe while condition present keeps flag
        sig_lost = 1'b1;
        @(negedge clk);
        alarm_clr_b = 1'b1;
        @(negedge clk);
        alarm_clr_b = 1'b0;
        healthy();
        do_read(5'd8, d);
        check("R7 strobe with live fault", d, 16'h8402);

        // R9: every unmapped address reads zero, even with flags set
        pll_locked = 1'b0;
        @(negedge clk);
        healthy();
        for (int a = 0; a < 32; a++) begin
            if (a != 8 && a != 24) begin
                do_read(5'(a), d);
                check("R9 unmapped", d, 16'h0000);
            end
        end

        // R10: rd_data holds without a strobe
        do_read(5'd24, d);
        rd_addr = 5'd8;
        lane_sync = 4'h3;
        repeat (4) @(negedge clk);
        check("R10 hold without strobe", rd_data, d);
        healthy();

        // R1: reset in mid-run clears data and flags
        pll_locked = 1'b0;
        @(negedge clk);
        healthy();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        do_read(5'd8, d);
        check("R1 reset clears flags", d, 16'h8002);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule